// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the target end of a three-wire control bus made of an active-low enable, a serial clock and one data line whose direction changes during a transfer. Behind the bus sits a bank of 24-bit registers with a 7-bit address space. The rest of the chip reads any register at any time through a combinational parallel port.

A frame begins once the enable is low. The master first sends 7 address bits, least significant bit first, and then a direction bit. A direction bit of 1 is a write: the master then sends 24 data bits, least significant first, and the register is updated only after the last of them arrives. A direction bit of 0 is a read: the slave drives the 24 register bits onto the data line, least significant first. Each bit changes on a falling serial-clock edge, so the master can sample it on the next rising edge.

All three bus lines are sampled by the system clock through synchronizers, and serial-clock edges are found by comparing samples. Register contents do not depend on any power state. They change only through a completed write frame or through reset.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset every register reads zero on the parallel port, `ser_doe` is 0 and `ser_dout` is 0.
- R2: On the first seven rising serial-clock edges of a frame the slave takes in the address, least significant bit first. The eighth rising edge takes in the direction bit, where 1 means write and 0 means read.
- R3: In a write frame, rising edges 9 to 32 take in data bits D0 to D23 in that order. The addressed register takes the new 24-bit value only after edge 32.
- R4: In a read frame, D0 of the addressed register appears on `ser_dout` after the falling edge that follows rising edge 8. Each later falling edge presents the next bit, up to D23, so the master samples D0 to D23 on rising edges 9 to 32. `ser_dout` never changes except after a falling serial-clock edge.
- R5: A read frame leaves every register unchanged.
- R6: If the enable rises before edge 32, no register changes and the next frame starts again from address bit 0.
- R7: `ser_doe` is 1 from the first read data bit until the enable rises, and it is never 1 during a write frame or while the enable is high.
- R8: Rising and falling serial-clock edges after edge 32 within the same enable-low window change no register, and `ser_dout` keeps holding D23.
- R9: A write to an address at or above `NUM_REGS` changes nothing, and a read of such an address returns 24 zero bits.
- R10: `rd_data` always shows the current contents of the register selected by `rd_addr`, or zero when `rd_addr` is at or above `NUM_REGS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Bus enable, active low |
| ser_clk | input | 1 | Serial clock from the master |
| ser_din | input | 1 | Data line as seen by the slave's input |
| ser_dout | output | 1 | Read data driven toward the data line |
| ser_doe | output | 1 | Output enable for the data-line driver |
| rd_addr | input | 7 | Parallel read address |
| rd_data | output | 24 | Parallel read data |

## Verification
The bench writes a distinct pattern to every register and reads each one back over the bus and through the parallel port. A reversed bit order, or a read that starts one falling edge early or late, shows up as a shifted or mirrored word. Aborted writes are cut off after only part of the data phase, which catches a design that commits bits as they arrive or keeps counting from the old frame. Overlong frames push inverted bits after edge 32, and a missing end-of-frame stop would write those bits or shift them out. Out-of-range addresses and a check of the driver enable during writes catch decoding that aliases addresses or turns the driver on at the wrong time.

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int AW       = 7,
  parameter int DW       = 24,
  parameter int NUM_REGS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_en_n,
  input  logic          ser_clk,
  input  logic          ser_din,
  output logic          ser_dout,
  output logic          ser_doe,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int FL = AW + 1 + DW;
  localparam int CW = $clog2(FL + 1);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [AW:0]   LIM    = (AW+1)'(NUM_REGS);
  localparam logic [CW-1:0] C_DIR  = CW'(AW);
  localparam logic [CW-1:0] C_LAST = CW'(FL - 1);
  localparam logic [CW-1:0] C_END  = CW'(FL);

  logic [2:0] ck_s;
  logic [1:0] en_s, din_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s  <= '0;
      en_s  <= 2'b11;
      din_s <= '0;
    end else begin
      ck_s  <= {ck_s[1:0], ser_clk};
      en_s  <= {en_s[0], ser_en_n};
      din_s <= {din_s[0], ser_din};
    end

  wire en_act = ~en_s[1];
  wire rise   = ck_s[1] & ~ck_s[2];
  wire fall   = ~ck_s[1] & ck_s[2];
  wire bit_in = din_s[1];

  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic          wr;
  logic [DW-1:0] sh;
  logic [DW-1:0] bank [NUM_REGS];

  wire          hit    = {1'b0, addr} < LIM;
  wire [IW-1:0] idx    = addr[IW-1:0];
  wire          rd_hit = {1'b0, rd_addr} < LIM;

  assign rd_data = rd_hit ? bank[rd_addr[IW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      addr     <= '0;
      wr       <= 1'b0;
      sh       <= '0;
      ser_dout <= 1'b0;
      ser_doe  <= 1'b0;
    end else if (!en_act) begin
      cnt     <= '0;
      ser_doe <= 1'b0;
    end else begin
      if (rise && cnt != C_END) begin
        cnt <= cnt + 1'b1;
        if (cnt < C_DIR)
          addr <= {bit_in, addr[AW-1:1]};
        else if (cnt == C_DIR) begin
          wr <= bit_in;
          if (!bit_in) sh <= hit ? bank[idx] : '0;
        end else if (wr)
          sh <= {bit_in, sh[DW-1:1]};
      end
      if (fall && !wr && cnt > C_DIR && cnt < C_END) begin
        ser_dout <= sh[0];
        sh       <= sh >> 1;
        ser_doe  <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (en_act && rise && wr && cnt == C_LAST && hit) begin
      bank[idx] <= {bit_in, sh[DW-1:1]};
    end
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
  parameter int CW = 6,
  parameter int AW = 7,
  parameter int FL = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_act,
  input logic          rise,
  input logic          fall,
  input logic [CW-1:0] cnt,
  input logic          wr,
  input logic          doe,
  input logic          dout
);
  localparam logic [CW-1:0] C_DIR = CW'(AW);
  localparam logic [CW-1:0] C_END = CW'(FL);

  a_r7_doe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> !doe);
  a_r7_doe_not_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && cnt > C_DIR && wr) |-> !doe);
  a_r4_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(dout));
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && cnt == C_END) |=> cnt == C_END);
  a_r6_abort_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> cnt == '0);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && rise && cnt != C_END) |=> cnt == $past(cnt) + 1'b1);
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.CW(CW), .AW(AW), .FL(FL)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_act(en_act), .rise(rise), .fall(fall),
  .cnt(cnt), .wr(wr), .doe(ser_doe), .dout(ser_dout)
);

// File: tb/tw_reg_slave_tb.sv
`timescale 1ns/1ps
module tw_reg_slave_tb;
  localparam int H = 8;
  localparam int NR = 16;

  logic clk = 0, rst_n = 0;
  logic sen = 1, sclk = 0, sdi = 0;
  logic dout, doe;
  logic [6:0] rd_addr = '0;
  logic [23:0] rd_data;
  logic [23:0] exp_m [NR];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tw_reg_slave #(.AW(7), .DW(24), .NUM_REGS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_en_n(sen), .ser_clk(sclk), .ser_din(sdi),
    .ser_dout(dout), .ser_doe(doe), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [23:0] pat(input int a, input int k);
    return 24'((a * 32'h0B4F1 + k * 32'h3A5C7) ^ 32'h5A5A5A);
  endfunction

  task automatic frame(input logic [6:0] a, input bit w, input logic [23:0] d,
                       input int nclk, output logic [23:0] q,
                       output bit doe_bad, output bit tail_bad);
    q = '0; doe_bad = 0; tail_bad = 0;
    sen = 0; tick(H);
    for (int i = 0; i < nclk; i++) begin
      if (i < 7)       sdi = a[i];
      else if (i == 7) sdi = w;
      else if (i < 32) sdi = d[i-8];
      else             sdi = ~d[(i-8) % 24];
      tick(H);
      if (i >= 8 && i < 32) begin
        if (!w) q[i-8] = dout;
        if (doe !== !w) doe_bad = 1;
      end
      if (i >= 32 && !w && dout !== q[23]) tail_bad = 1;
      sclk = 1; tick(H);
      sclk = 0;
    end
    tick(H);
    sen = 1; sdi = 0;
    tick(2*H);
  endtask

  task automatic check_bank(input string req);
    for (int a = 0; a < NR; a++) begin
      rd_addr = 7'(a); tick(1);
      chk(rd_data === exp_m[a], req, rd_data, exp_m[a]);
    end
  endtask

  initial begin
    fork
      begin
        repeat (195000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=%h expected=%h", 24'h0, 24'h1);
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [23:0] q;
    bit db, tb;
    for (int a = 0; a < NR; a++) exp_m[a] = '0;
    tick(5); rst_n = 1; tick(5);

    // R1 reset state
    chk(doe === 1'b0, "R1 doe", {23'b0, doe}, 24'h0);
    chk(dout === 1'b0, "R1 dout", {23'b0, dout}, 24'h0);
    check_bank("R1/R10 reset bank");

    // R2 R3 writes to every register, LSB first
    for (int a = 0; a < NR; a++) begin
      frame(7'(a), 1, pat(a, 1), 32, q, db, tb);
      exp_m[a] = pat(a, 1);
      chk(!db, "R7 doe during write", {23'b0, db}, 24'h0);
      chk(doe === 1'b0, "R7 doe after write", {23'b0, doe}, 24'h0);
    end
    check_bank("R3/R10 write readback");

    // R4 serial read of every register, R5 no change
    for (int a = 0; a < NR; a++) begin
      frame(7'(a), 0, 24'h0, 32, q, db, tb);
      chk(q === exp_m[a], "R4 read data", q, exp_m[a]);
      chk(!db, "R7 doe during read", {23'b0, db}, 24'h0);
      chk(doe === 1'b0, "R7 doe released", {23'b0, doe}, 24'h0);
    end
    check_bank("R5 read leaves bank");

    // R9 out-of-range writes and reads
    for (int a = NR; a < 128; a += 3) frame(7'(a), 1, pat(a, 2), 32, q, db, tb);
    check_bank("R9 out-of-range write ignored");
    frame(7'd100, 0, 24'h0, 32, q, db, tb);
    chk(q === 24'h0, "R9 out-of-range read", q, 24'h0);
    rd_addr = 7'd77; tick(1);
    chk(rd_data === 24'h0, "R10 out-of-range parallel", rd_data, 24'h0);

    // R6 aborted writes at several lengths
    for (int n = 3; n < 32; n += 7) begin
      frame(7'd5, 1, pat(n, 3), n, q, db, tb);
      rd_addr = 7'd5; tick(1);
      chk(rd_data === exp_m[5], "R6 abort no write", rd_data, exp_m[5]);
    end
    frame(7'd6, 1, 24'hA5C3E1, 32, q, db, tb);
    exp_m[6] = 24'hA5C3E1;
    rd_addr = 7'd6; tick(1);
    chk(rd_data === exp_m[6], "R6 fresh frame after abort", rd_data, exp_m[6]);

    // R8 overlong frames
    frame(7'd3, 1, 24'h123456, 40, q, db, tb);
    exp_m[3] = 24'h123456;
    check_bank("R8 extra write edges ignored");
    frame(7'd3, 0, 24'h0, 40, q, db, tb);
    chk(q === exp_m[3], "R8 read data overlong", q, exp_m[3]);
    chk(!tb, "R8 dout holds D23", {23'b0, tb}, 24'h0);
    chk(doe === 1'b0, "R7 doe released overlong", {23'b0, doe}, 24'h0);

    // R2 direction decode: all-ones word read at top address
    frame(7'd15, 1, 24'hFFFFFF, 32, q, db, tb);
    exp_m[15] = 24'hFFFFFF;
    frame(7'd15, 0, 24'h0, 32, q, db, tb);
    chk(q === 24'hFFFFFF, "R2 direction and top address", q, 24'hFFFFFF);
    check_bank("R5 final bank");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule